// File: doc/BRIEF.md
# Indexed Address Generator with Register Auto-Step

This block forms the effective address of an indexed memory operand for a small 8-bit style processor core. It holds four 16-bit pointer registers. One of them, or the program counter supplied on an input, is the base. An 8-bit control byte picks the base and the kind of signed offset to add. It can also ask for an automatic post-increment or pre-decrement of the base register, and for one level of indirection through memory.

When indirection is requested, the indexed address points at a two-byte pointer in memory. The block reads that pointer high byte first through a single-cycle read port, and the result becomes the effective address. Auto-step modes write the stepped value back into the pointer register. The write is reported on the writeback outputs in the same cycle as the one-cycle `done` pulse.

A separate load port lets the surrounding core set any pointer register.

Top module: `idx_unit`

## Requirements
- R1: After reset, `done`, `illegal`, `wb_en` and `mem_rd` are 0, `ea` is 0 and all four pointer registers hold 0.
- R2: `ctl[1:0]` selects the base register (0 = X, 1 = Y, 2 = U, 3 = S). When `ctl[2]` is 1, the `pc` input is the base instead.
- R3: With `ctl[6:5]` = 00, the offset is chosen by `ctl[4:3]`: 00 adds nothing, 01 adds `offset[7:0]` sign-extended, 10 adds all 16 bits of `offset`, and 11 adds `offset[3:0]` sign-extended. Offset bits above the chosen field have no effect.
- R4: With `ctl[6:5]` = 01 (post-increment), `ea` is the old register value and the register becomes old + step. The step is 1 when `ctl[3]` is 0 and 2 when it is 1. The offset is not added, and the arithmetic wraps modulo 2^16.
- R5: With `ctl[6:5]` = 10 (pre-decrement), the register becomes old − step and `ea` is that new value. The step is chosen as in R4, and the arithmetic wraps modulo 2^16.
- R6: Without indirection, `done` pulses for one cycle, one clock after `start` is accepted. `ea`, `wb_en`, `wb_sel` and `wb_data` are valid in that same cycle. `wb_en` is 1 only for auto-step modes, and the register holds the new value from then on.
- R7: With `ctl[7]` = 1, the indexed address A is used to read memory in two consecutive cycles, at A and then at A+1, with `mem_rd` high in both. `ea` = {byte at A, byte at A+1}, and `done` comes 3 clocks after `start`. `mem_rd` is never high otherwise.
- R8: The block flags an illegal request in three cases: `ctl[6:5]` = 11; an auto-step with the PC as base; or an auto-step with step 1 combined with indirection. Such a request gives `done` after one clock with `illegal` = 1, `ea` = 0, no memory read and no register change.
- R9: `start` is ignored while an indirect request is in progress.
- R10: When `ld_en` is 1 at a clock edge, `ld_data` is written into the register selected by `ld_sel`, using the encoding of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request an address calculation |
| ctl | input | 8 | Mode control byte |
| offset | input | 16 | Signed offset source |
| pc | input | 16 | Program counter used as base when selected |
| ld_en | input | 1 | Pointer register load strobe |
| ld_sel | input | 2 | Pointer register to load |
| ld_data | input | 16 | Load value |
| mem_rd | output | 1 | Memory read strobe for indirect pointer |
| mem_addr | output | 16 | Memory read address |
| mem_rdata | input | 8 | Read data, valid in the same cycle as the address |
| done | output | 1 | One-cycle completion pulse |
| illegal | output | 1 | Illegal mode combination, valid with done |
| ea | output | 16 | Effective address, valid with done |
| wb_en | output | 1 | Pointer register was updated |
| wb_sel | output | 2 | Register that was updated |
| wb_data | output | 16 | Value written back |

## Verification
A stale or wrong pointer register appears at `ea` on the very next zero-offset request that reads it back, so every case reloads the registers and reads the written register after the operation. A wrong state-machine step appears as a `done` that arrives at the wrong clock, or as a second pointer byte read from the wrong address. Both are visible within three cycles of `start`. Illegal combinations are confirmed at the ports by reading the register back unchanged.

// File: rtl/idx_unit.sv
module idx_unit (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [7:0]  ctl,
  input  logic [15:0] offset,
  input  logic [15:0] pc,
  input  logic        ld_en,
  input  logic [1:0]  ld_sel,
  input  logic [15:0] ld_data,
  output logic        mem_rd,
  output logic [15:0] mem_addr,
  input  logic [7:0]  mem_rdata,
  output logic        done,
  output logic        illegal,
  output logic [15:0] ea,
  output logic        wb_en,
  output logic [1:0]  wb_sel,
  output logic [15:0] wb_data
);
  typedef enum logic [1:0] {IDLE, PHI, PLO} st_t;
  st_t st;

  logic [15:0] rf [4];
  logic [15:0] ptr, pdata;
  logic [7:0]  hi;
  logic        pend;
  logic [1:0]  psel;

  wire        use_pc = ctl[2];
  wire [1:0]  amode  = ctl[6:5];
  wire        ind    = ctl[7];
  wire [15:0] base   = use_pc ? pc : rf[ctl[1:0]];
  wire [15:0] step   = ctl[3] ? 16'd2 : 16'd1;

  logic [15:0] off;
  always_comb
    case (ctl[4:3])
      2'b00:   off = 16'h0000;
      2'b01:   off = {{8{offset[7]}}, offset[7:0]};
      2'b10:   off = offset;
      default: off = {{12{offset[3]}}, offset[3:0]};
    endcase

  wire [15:0] stepped = (amode == 2'b01) ? base + step : base - step;
  wire [15:0] addr    = (amode == 2'b00) ? base + off :
                        (amode == 2'b01) ? base : stepped;
  wire        bad     = (amode == 2'b11) || (amode != 2'b00 && use_pc) ||
                        (amode != 2'b00 && !ctl[3] && ind);
  wire        go      = start && st == IDLE;

  wire        fin_now = go && !bad && !ind;
  wire        fin     = fin_now || st == PLO;
  wire [15:0] fin_ea  = fin_now ? addr : {hi, mem_rdata};
  wire        fin_wb  = fin_now ? (amode != 2'b00) : pend;
  wire [15:0] fin_d   = fin_now ? stepped : pdata;
  wire [1:0]  fin_s   = fin_now ? ctl[1:0] : psel;

  assign mem_rd   = st != IDLE;
  assign mem_addr = (st == PLO) ? ptr + 16'd1 : ptr;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= IDLE;
      ptr     <= '0;
      pdata   <= '0;
      hi      <= '0;
      pend    <= 1'b0;
      psel    <= '0;
      done    <= 1'b0;
      illegal <= 1'b0;
      ea      <= '0;
      wb_en   <= 1'b0;
      wb_sel  <= '0;
      wb_data <= '0;
      for (int i = 0; i < 4; i++) rf[i] <= '0;
    end else begin
      done    <= 1'b0;
      illegal <= 1'b0;
      wb_en   <= 1'b0;
      if (ld_en) rf[ld_sel] <= ld_data;
      case (st)
        IDLE: if (go) begin
          if (bad) begin
            done    <= 1'b1;
            illegal <= 1'b1;
            ea      <= '0;
          end else if (ind) begin
            ptr   <= addr;
            pend  <= amode != 2'b00;
            pdata <= stepped;
            psel  <= ctl[1:0];
            st    <= PHI;
          end
        end
        PHI: begin
          hi <= mem_rdata;
          st <= PLO;
        end
        default: st <= IDLE;
      endcase
      if (fin) begin
        done    <= 1'b1;
        ea      <= fin_ea;
        wb_en   <= fin_wb;
        wb_sel  <= fin_s;
        wb_data <= fin_d;
        if (fin_wb) rf[fin_s] <= fin_d;
      end
    end
  end
endmodule

module idx_unit_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        mem_rd,
  input logic [15:0] mem_addr,
  input logic        done,
  input logic        illegal,
  input logic        wb_en,
  input logic [15:0] ea
);
  // R6
  wb_needs_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> done && !illegal);
  // R8
  illegal_zero_ea_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> done && ea == 16'h0000);
  // R7
  read_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_rd) |-> $past(start));
  // R7
  second_byte_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd && $past(mem_rd) |-> mem_addr == $past(mem_addr) + 16'd1);
  // R7
  no_read_at_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_rd);
endmodule

bind idx_unit idx_unit_chk u_chk (.*);

// File: tb/test_idx_unit.sv
module test_idx_unit;
  localparam int CLK_P = 10;

  logic clk = 0, rst_n = 0, start = 0, ld_en = 0;
  logic [7:0] ctl = 0;
  logic [15:0] offset = 0, pc = 0, ld_data = 0;
  logic [1:0] ld_sel = 0;
  logic mem_rd, done, illegal, wb_en;
  logic [15:0] mem_addr, ea, wb_data;
  logic [1:0] wb_sel;
  logic [7:0] mem_rdata;

  int n_chk = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  function automatic logic [7:0] mbyte(input logic [15:0] a);
    return a[7:0] + a[15:8] + 8'h3C;
  endfunction
  assign mem_rdata = mbyte(mem_addr);

  idx_unit i_idx_unit (.*);

  task automatic chk(input bit ok, input string req, input logic [15:0] act, exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load(input logic [1:0] s, input logic [15:0] d);
    ld_en = 1; ld_sel = s; ld_data = d;
    @(posedge clk); #1 ld_en = 0;
  endtask

  task automatic preload;
    load(0, 16'h1000); load(1, 16'h2000); load(2, 16'h3000); load(3, 16'h4000);
  endtask

  task automatic op(input logic [7:0] c, input logic [15:0] o, p, output int lat);
    ctl = c; offset = o; pc = p; start = 1;
    @(posedge clk); #1 start = 0;
    lat = 1;
    while (!done && lat < 20) begin @(posedge clk); #1; lat++; end
  endtask

  task automatic readreg(input logic [1:0] s, output logic [15:0] v);
    int l;
    op({6'b0, s}, 16'hFFFF, 16'h0, l);
    v = ea;
  endtask

  typedef struct packed {
    logic [7:0]  c;
    logic [15:0] o;
    logic [15:0] p;
    logic [15:0] a;
    logic        w;
    logic [15:0] d;
    logic        il;
  } vec_t;

  localparam int NV = 15;
  localparam vec_t VT [NV] = '{
    '{8'h08, 16'h00F0, 16'h0, 16'h0FF0, 1'b0, 16'h0, 1'b0},
    '{8'h11, 16'h1234, 16'h0, 16'h3234, 1'b0, 16'h0, 1'b0},
    '{8'h1A, 16'hABC9, 16'h0, 16'h2FF9, 1'b0, 16'h0, 1'b0},
    '{8'h03, 16'h5555, 16'h0, 16'h4000, 1'b0, 16'h0, 1'b0},
    '{8'h0C, 16'hFF7F, 16'h8000, 16'h807F, 1'b0, 16'h0, 1'b0},
    '{8'h28, 16'h0077, 16'h0, 16'h1000, 1'b1, 16'h1002, 1'b0},
    '{8'h42, 16'h0000, 16'h0, 16'h2FFF, 1'b1, 16'h2FFF, 1'b0},
    '{8'h4B, 16'h0000, 16'h0, 16'h3FFE, 1'b1, 16'h3FFE, 1'b0},
    '{8'h21, 16'h0000, 16'h0, 16'h2000, 1'b1, 16'h2001, 1'b0},
    '{8'h90, 16'h0010, 16'h0, 16'h1010, 1'b0, 16'h0, 1'b0},
    '{8'hCB, 16'h0000, 16'h0, 16'h3FFE, 1'b1, 16'h3FFE, 1'b0},
    '{8'h8C, 16'h0010, 16'h00F0, 16'h0100, 1'b0, 16'h0, 1'b0},
    '{8'hA0, 16'h0000, 16'h0, 16'h0000, 1'b0, 16'h0, 1'b1},
    '{8'h2C, 16'h0000, 16'h0, 16'h0000, 1'b0, 16'h0, 1'b1},
    '{8'h60, 16'h0000, 16'h0, 16'h0000, 1'b0, 16'h0, 1'b1}
  };

  initial begin
    #(CLK_P * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 16'h0, 16'h1);
    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] v, expea, pre;
    int lat, ndone;
    repeat (3) @(posedge clk);
    #1;
    // R1
    chk(!done && !illegal && !wb_en && !mem_rd, "R1 flags", {12'h0, done, illegal, wb_en, mem_rd}, 16'h0);
    chk(ea == 0, "R1 ea", ea, 16'h0);
    rst_n = 1;
    @(posedge clk); #1;
    for (int r = 0; r < 4; r++) begin
      readreg(r[1:0], v);
      chk(v == 0, "R1 register cleared", v, 16'h0);
    end

    // R2 R3 R4 R5 R6 R7 R8 R10 table
    for (int k = 0; k < NV; k++) begin
      vec_t t = VT[k];
      preload;
      pre = 16'h1000 * (t.c[1:0] + 1);
      expea = t.il ? 16'h0 : t.c[7] ? {mbyte(t.a), mbyte(t.a + 16'd1)} : t.a;
      op(t.c, t.o, t.p, lat);
      chk(ea == expea, "R2/R3/R4/R5/R7 ea", ea, expea);
      chk(illegal == t.il, "R8 illegal flag", {15'h0, illegal}, {15'h0, t.il});
      chk(lat == ((t.c[7] && !t.il) ? 3 : 1), "R6/R7 latency", lat[15:0], (t.c[7] && !t.il) ? 16'd3 : 16'd1);
      chk(wb_en == t.w, "R6 wb_en", {15'h0, wb_en}, {15'h0, t.w});
      if (t.w) begin
        chk(wb_data == t.d, "R4/R5 wb_data", wb_data, t.d);
        chk(wb_sel == t.c[1:0], "R6 wb_sel", {14'h0, wb_sel}, {14'h0, t.c[1:0]});
      end
      @(posedge clk); #1;
      chk(!done, "R6 done single pulse", {15'h0, done}, 16'h0);
      readreg(t.c[1:0], v);
      chk(v == (t.w ? t.d : pre), "R10/R8 register after op", v, t.w ? t.d : pre);
    end

    // R4 wrap
    load(0, 16'hFFFF);
    op(8'h28, 16'h0, 16'h0, lat);
    chk(ea == 16'hFFFF && wb_data == 16'h0001, "R4 wrap", wb_data, 16'h0001);
    // R5 wrap
    load(1, 16'h0000);
    op(8'h41, 16'h0, 16'h0, lat);
    chk(ea == 16'hFFFF && wb_data == 16'hFFFF, "R5 wrap", ea, 16'hFFFF);

    // R9: start held during indirect request
    preload;
    ctl = 8'h90; offset = 16'h0010; start = 1; ndone = 0;
    for (int c = 0; c < 3; c++) begin
      @(posedge clk); #1;
      if (c == 1) begin ctl = 8'h01; offset = 0; end
      ndone += done;
    end
    start = 0;
    expea = {mbyte(16'h1010), mbyte(16'h1011)};
    chk(done && ea == expea, "R9 first request result", ea, expea);
    for (int c = 0; c < 3; c++) begin @(posedge clk); #1; ndone += done; end
    chk(ndone == 1, "R9 start ignored while busy", ndone[15:0], 16'd1);
    // R7 no read when idle
    chk(!mem_rd, "R7 mem_rd idle", {15'h0, mem_rd}, 16'h0);

    $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end
endmodule